// File: doc/BRIEF.md
# Machine-Mode Control Register and Trap State Unit

This unit holds the machine-mode control and status registers of a small 32-bit RISC-V core. The writeback stage presents one register access per cycle: a 12-bit register address, a source operand and an operation code. The unit returns the addressed register's current contents on the same cycle and applies a full write, a bit-set or a bit-clear at the next clock edge.

The unit also keeps the trap state. When the core takes a trap, the unit stores the trap PC and the cause code. It also moves the global interrupt enable into its saved copy and clears the live enable. A trap-return strobe reverses this. The three interrupt lines (external, timer, software) are registered into the pending register on every cycle. A single request flag tells the core that an enabled interrupt is pending while interrupts are globally enabled. The decision to take a trap is made outside this unit. The unit exposes the trap vector base and the saved exception PC for the core's next-PC logic.

Top module: `mcsr_unit`

## Requirements
- R1: After reset every register reads zero, `irq_req` is 0 and `mtvec_o` and `mepc_o` are zero.
- R2: Register addresses are 0x300 status, 0x304 interrupt enable, 0x305 trap vector, 0x341 exception PC, 0x342 cause, 0x343 trap value and 0x344 interrupt pending. `csr_rdata` returns the addressed register combinationally, and any other address reads zero and ignores writes.
- R3: `csr_op` 2'b01 replaces the register with `csr_src`, 2'b10 ORs `csr_src` into it, 2'b11 clears the bits set in `csr_src`, and 2'b00 only reads. A set or clear with a zero source does not write.
- R4: Only status bits 3 (global enable) and 7 (saved enable) and enable bits 11, 7 and 3 are stored. All other bits of these two registers read zero.
- R5: Pending bit 11 follows `irq_ext`, bit 7 follows `irq_tmr` and bit 3 follows `irq_sw`, each one clock later. Software writes to the pending register have no effect.
- R6: `irq_req` is 1 exactly when status bit 3 is set and the AND of the pending and enable registers is nonzero.
- R7: On `trap_en`, the exception PC takes `trap_pc`, the cause takes `trap_cause`, status bit 7 takes the old bit 3, and bit 3 clears.
- R8: On `mret_en` without `trap_en`, status bit 3 takes the old bit 7, and bit 7 is set.
- R9: When `trap_en` and `mret_en` are both high, only trap entry takes effect. A register operation in a cycle with either strobe high writes nothing.
- R10: `mtvec_o` and `mepc_o` show the trap vector and exception PC registers. Trap vector bits 1:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address of the access |
| csr_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csr_src | input | 32 | Source operand of the access |
| csr_rdata | output | 32 | Current contents of the addressed register |
| trap_en | input | 1 | Trap entry strobe |
| trap_pc | input | 32 | PC saved on trap entry |
| trap_cause | input | 32 | Cause code saved on trap entry |
| mret_en | input | 1 | Trap return strobe |
| irq_ext | input | 1 | External interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_sw | input | 1 | Software interrupt line |
| mtvec_o | output | 32 | Trap vector base |
| mepc_o | output | 32 | Saved exception PC |
| irq_req | output | 1 | Enabled interrupt pending and globally enabled |

## Verification
Trap entry and trap return can fall in the same cycle. So can either of them and a software register write to the status or exception PC register. The bench drives `trap_en` and `mret_en` high on the same edge from a known enable state. It then reads the status register and accepts only the trap-entry result, 0x80 from 0x08. It also pairs a trap with a write of a different value to the exception PC, and a return with a write of zero to the status register. In both cases the bench expects the strobe's result and the software value to be lost.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XLEN   = 32;
    localparam int AWIDTH = 12;
    localparam int NIRQ   = 3;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [AWIDTH-1:0] addr_t;

    localparam addr_t A_STATUS = 12'h300;
    localparam addr_t A_IEN    = 12'h304;
    localparam addr_t A_TVEC   = 12'h305;
    localparam addr_t A_EPC    = 12'h341;
    localparam addr_t A_CAUSE  = 12'h342;
    localparam addr_t A_TVAL   = 12'h343;
    localparam addr_t A_IPEND  = 12'h344;

    localparam int GIE_BIT  = 3;
    localparam int SGIE_BIT = 7;

    // index 0 software, 1 timer, 2 external
    localparam int IRQ_POS [NIRQ] = '{3, 7, 11};

    localparam int TVEC_ALIGN = 2;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } op_e;

    typedef struct packed {
        logic sgie;
        logic gie;
    } status_t;

    function automatic word_t merge_op(word_t old_v, word_t src, op_e op);
        word_t r;
        unique case (op)
            OP_WRITE: r = src;
            OP_SET:   r = old_v | src;
            OP_CLEAR: r = old_v & ~src;
            default:  r = old_v;
        endcase
        return r;
    endfunction

    function automatic word_t status_word(status_t s);
        word_t w;
        w = '0;
        w[GIE_BIT]  = s.gie;
        w[SGIE_BIT] = s.sgie;
        return w;
    endfunction

    function automatic word_t spread_irq(logic [NIRQ-1:0] bits);
        word_t w;
        w = '0;
        for (int i = 0; i < NIRQ; i++) w[IRQ_POS[i]] = bits[i];
        return w;
    endfunction

    function automatic logic [NIRQ-1:0] gather_irq(word_t w);
        logic [NIRQ-1:0] b;
        for (int i = 0; i < NIRQ; i++) b[i] = w[IRQ_POS[i]];
        return b;
    endfunction

endpackage

// File: rtl/mcsr_status.sv
module mcsr_status
    import mcsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  word_t   wr_data,
    input  logic    trap_en,
    input  logic    mret_en,
    output status_t st_o
);
    status_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (trap_en) begin
            st_q.sgie <= st_q.gie;
            st_q.gie  <= 1'b0;
        end else if (mret_en) begin
            st_q.gie  <= st_q.sgie;
            st_q.sgie <= 1'b1;
        end else if (wr_en) begin
            st_q.gie  <= wr_data[GIE_BIT];
            st_q.sgie <= wr_data[SGIE_BIT];
        end
    end

    assign st_o = st_q;

    // R7
    trap_stack_push_chk: assert property (@(posedge clk) disable iff (rst)
        trap_en |=> (!st_q.gie && st_q.sgie == $past(st_q.gie)));

    // R8
    trap_stack_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (mret_en && !trap_en) |=> (st_q.sgie && st_q.gie == $past(st_q.sgie)));

endmodule

// File: rtl/mcsr_irq.sv
module mcsr_irq
    import mcsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] lines_i,
    input  logic            ien_wr,
    input  word_t           ien_data,
    output word_t           ipend_o,
    output word_t           ien_o,
    output logic            any_o
);
    logic [NIRQ-1:0] pend_q;
    logic [NIRQ-1:0] en_q;

    for (genvar g = 0; g < NIRQ; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
                en_q[g]   <= 1'b0;
            end else begin
                pend_q[g] <= lines_i[g];
                if (ien_wr) en_q[g] <= ien_data[IRQ_POS[g]];
            end
        end
    end

    assign ipend_o = spread_irq(pend_q);
    assign ien_o   = spread_irq(en_q);
    assign any_o   = |(pend_q & en_q);

    // R5
    pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (pend_q == $past(lines_i)));

endmodule

// File: rtl/mcsr_trapregs.sv
module mcsr_trapregs
    import mcsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  trap_en,
    input  word_t trap_pc,
    input  word_t trap_cause,
    input  logic  tvec_wr,
    input  logic  epc_wr,
    input  logic  cause_wr,
    input  logic  tval_wr,
    input  word_t wr_data,
    output word_t tvec_o,
    output word_t epc_o,
    output word_t cause_o,
    output word_t tval_o
);
    logic [XLEN-1:TVEC_ALIGN] tvec_q;
    word_t epc_q, cause_q, tval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tvec_q  <= '0;
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else begin
            if (tvec_wr) tvec_q <= wr_data[XLEN-1:TVEC_ALIGN];
            if (tval_wr) tval_q <= wr_data;
            if (trap_en) begin
                epc_q   <= trap_pc;
                cause_q <= trap_cause;
            end else begin
                if (epc_wr)   epc_q   <= wr_data;
                if (cause_wr) cause_q <= wr_data;
            end
        end
    end

    assign tvec_o  = {tvec_q, {TVEC_ALIGN{1'b0}}};
    assign epc_o   = epc_q;
    assign cause_o = cause_q;
    assign tval_o  = tval_q;

    // R7
    trap_save_chk: assert property (@(posedge clk) disable iff (rst)
        trap_en |=> (epc_q == $past(trap_pc) && cause_q == $past(trap_cause)));

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  csr_op,
    input  logic [31:0] csr_src,
    output logic [31:0] csr_rdata,
    input  logic        trap_en,
    input  logic [31:0] trap_pc,
    input  logic [31:0] trap_cause,
    input  logic        mret_en,
    input  logic        irq_ext,
    input  logic        irq_tmr,
    input  logic        irq_sw,
    output logic [31:0] mtvec_o,
    output logic [31:0] mepc_o,
    output logic        irq_req
);
    op_e     op;
    status_t st;
    word_t   ipend, ien, tvec, epc, cause, tval;
    word_t   rd_val, new_val;
    logic    any_pend, wr_go;

    assign op = op_e'(csr_op);

    always_comb begin
        unique case (csr_addr)
            A_STATUS: rd_val = status_word(st);
            A_IEN:    rd_val = ien;
            A_TVEC:   rd_val = tvec;
            A_EPC:    rd_val = epc;
            A_CAUSE:  rd_val = cause;
            A_TVAL:   rd_val = tval;
            A_IPEND:  rd_val = ipend;
            default:  rd_val = '0;
        endcase
    end

    assign new_val = merge_op(rd_val, csr_src, op);
    assign wr_go   = (op != OP_READ) && !trap_en && !mret_en
                   && (op == OP_WRITE || csr_src != '0);

    mcsr_status u_status (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go && csr_addr == A_STATUS),
        .wr_data (new_val),
        .trap_en (trap_en),
        .mret_en (mret_en),
        .st_o    (st)
    );

    mcsr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .lines_i  ({irq_ext, irq_tmr, irq_sw}),
        .ien_wr   (wr_go && csr_addr == A_IEN),
        .ien_data (new_val),
        .ipend_o  (ipend),
        .ien_o    (ien),
        .any_o    (any_pend)
    );

    mcsr_trapregs u_trap (
        .clk        (clk),
        .rst        (rst),
        .trap_en    (trap_en),
        .trap_pc    (trap_pc),
        .trap_cause (trap_cause),
        .tvec_wr    (wr_go && csr_addr == A_TVEC),
        .epc_wr     (wr_go && csr_addr == A_EPC),
        .cause_wr   (wr_go && csr_addr == A_CAUSE),
        .tval_wr    (wr_go && csr_addr == A_TVAL),
        .wr_data    (new_val),
        .tvec_o     (tvec),
        .epc_o      (epc),
        .cause_o    (cause),
        .tval_o     (tval)
    );

    assign csr_rdata = rd_val;
    assign mtvec_o   = tvec;
    assign mepc_o    = epc;
    assign irq_req   = st.gie && any_pend;

    // R6
    req_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(irq_ext || irq_tmr || irq_sw));

    // R9
    trap_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
        trap_en |=> (mepc_o == $past(trap_pc)));

    // R10
    tvec_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mtvec_o[1:0] == 2'b00);

endmodule

// File: tb/tb_mcsr_unit.sv
module tb_mcsr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_src = '0;
    logic [31:0] csr_rdata;
    logic        trap_en = 1'b0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_cause = '0;
    logic        mret_en = 1'b0;
    logic        irq_ext = 1'b0, irq_tmr = 1'b0, irq_sw = 1'b0;
    logic [31:0] mtvec_o, mepc_o;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mcsr_unit dut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_op(csr_op),
        .csr_src(csr_src), .csr_rdata(csr_rdata), .trap_en(trap_en),
        .trap_pc(trap_pc), .trap_cause(trap_cause), .mret_en(mret_en),
        .irq_ext(irq_ext), .irq_tmr(irq_tmr), .irq_sw(irq_sw),
        .mtvec_o(mtvec_o), .mepc_o(mepc_o), .irq_req(irq_req)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
        csr_addr = a; csr_op = 2'b00; csr_src = '0;
        #1;
        chk(tag, csr_rdata, exp);
    endtask

    task automatic acc(logic [1:0] op, logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        csr_addr = a; csr_op = op; csr_src = v;
        @(negedge clk);
        csr_op = 2'b00; csr_src = '0;
    endtask

    task automatic t_reset;
        rd("R1 status", 12'h300, 0); rd("R1 ien", 12'h304, 0);
        rd("R1 tvec", 12'h305, 0);   rd("R1 epc", 12'h341, 0);
        rd("R1 cause", 12'h342, 0);  rd("R1 tval", 12'h343, 0);
        rd("R1 ipend", 12'h344, 0);
        chk("R1 irq_req", {31'b0, irq_req}, 0);
        chk("R1 mtvec_o", mtvec_o, 0);
        chk("R1 mepc_o", mepc_o, 0);
    endtask

    task automatic t_map;
        acc(2'b01, 12'h305, 32'h8000_0103);
        rd("R10 tvec aligned", 12'h305, 32'h8000_0100);
        chk("R10 mtvec_o", mtvec_o, 32'h8000_0100);
        acc(2'b01, 12'h341, 32'h0000_1234);
        rd("R2 epc", 12'h341, 32'h0000_1234);
        chk("R10 mepc_o", mepc_o, 32'h0000_1234);
        acc(2'b01, 12'h342, 32'h0000_0005);
        rd("R2 cause", 12'h342, 32'h0000_0005);
        acc(2'b01, 12'h123, 32'hFFFF_FFFF);
        rd("R2 unmapped", 12'h123, 0);
        rd("R2 tval untouched", 12'h343, 0);
    endtask

    task automatic t_ops;
        acc(2'b01, 12'h343, 32'h0000_F0F0);
        rd("R3 write", 12'h343, 32'h0000_F0F0);
        acc(2'b10, 12'h343, 32'h0000_000F);
        rd("R3 set", 12'h343, 32'h0000_F0FF);
        acc(2'b11, 12'h343, 32'h0000_00F0);
        rd("R3 clear", 12'h343, 32'h0000_F00F);
        acc(2'b10, 12'h343, 32'h0);
        rd("R3 set zero", 12'h343, 32'h0000_F00F);
        acc(2'b11, 12'h343, 32'h0);
        rd("R3 clear zero", 12'h343, 32'h0000_F00F);
    endtask

    task automatic t_masks;
        acc(2'b01, 12'h300, 32'hFFFF_FFFF);
        rd("R4 status mask", 12'h300, 32'h0000_0088);
        acc(2'b01, 12'h304, 32'hFFFF_FFFF);
        rd("R4 ien mask", 12'h304, 32'h0000_0888);
        acc(2'b01, 12'h300, 32'h0);
        acc(2'b01, 12'h304, 32'h0);
    endtask

    task automatic t_pending;
        @(negedge clk); irq_ext = 1'b1;
        @(negedge clk);
        rd("R5 ext", 12'h344, 32'h0000_0800);
        irq_tmr = 1'b1; irq_sw = 1'b1;
        @(negedge clk);
        rd("R5 all", 12'h344, 32'h0000_0888);
        acc(2'b01, 12'h344, 32'h0);
        rd("R5 write ignored", 12'h344, 32'h0000_0888);
        irq_ext = 1'b0; irq_tmr = 1'b0; irq_sw = 1'b0;
        @(negedge clk);
        rd("R5 cleared", 12'h344, 0);
    endtask

    task automatic t_request;
        acc(2'b01, 12'h304, 32'h0000_0080);
        acc(2'b01, 12'h300, 32'h0000_0008);
        irq_tmr = 1'b1;
        @(negedge clk);
        chk("R6 timer enabled", {31'b0, irq_req}, 1);
        acc(2'b11, 12'h300, 32'h0000_0008);
        chk("R6 global off", {31'b0, irq_req}, 0);
        acc(2'b10, 12'h300, 32'h0000_0008);
        acc(2'b01, 12'h304, 32'h0000_0008);
        chk("R6 source masked", {31'b0, irq_req}, 0);
        irq_tmr = 1'b0;
        acc(2'b01, 12'h304, 32'h0);
    endtask

    task automatic t_trap;
        acc(2'b01, 12'h300, 32'h0000_0008);
        @(negedge clk);
        trap_en = 1'b1; trap_pc = 32'h0000_0400; trap_cause = 32'h8000_000B;
        @(negedge clk);
        trap_en = 1'b0;
        rd("R7 epc", 12'h341, 32'h0000_0400);
        rd("R7 cause", 12'h342, 32'h8000_000B);
        rd("R7 status", 12'h300, 32'h0000_0080);
        mret_en = 1'b1;
        @(negedge clk);
        mret_en = 1'b0;
        rd("R8 restore", 12'h300, 32'h0000_0088);
        acc(2'b01, 12'h300, 32'h0);
        mret_en = 1'b1;
        @(negedge clk);
        mret_en = 1'b0;
        rd("R8 restore zero", 12'h300, 32'h0000_0080);
    endtask

    task automatic t_collide;
        acc(2'b01, 12'h300, 32'h0000_0008);
        @(negedge clk);
        trap_en = 1'b1; mret_en = 1'b1; trap_pc = 32'h0000_0800; trap_cause = 32'h2;
        @(negedge clk);
        trap_en = 1'b0; mret_en = 1'b0;
        rd("R9 trap wins", 12'h300, 32'h0000_0080);
        chk("R9 epc", mepc_o, 32'h0000_0800);
        @(negedge clk);
        trap_en = 1'b1; trap_pc = 32'h0000_0C00; trap_cause = 32'h7;
        csr_addr = 12'h341; csr_op = 2'b01; csr_src = 32'h0000_DEAD;
        @(negedge clk);
        trap_en = 1'b0; csr_op = 2'b00;
        rd("R9 write lost to trap", 12'h341, 32'h0000_0C00);
        @(negedge clk);
        mret_en = 1'b1;
        csr_addr = 12'h300; csr_op = 2'b01; csr_src = 32'h0;
        @(negedge clk);
        mret_en = 1'b0; csr_op = 2'b00;
        rd("R9 write lost to return", 12'h300, 32'h0000_0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_map;
        t_ops;
        t_masks;
        t_pending;
        t_request;
        t_trap;
        t_collide;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule